// File: doc/BRIEF.md
# Square-Fold Modular Transform Engine

This block computes a length-n number-theoretic transform over a small prime field. The length must be a square, n = k². The input vector is folded into a k-by-k matrix, with word m placed at row m / k and column m % k (0-based). The block then works through two k-point matrix products with an element-wise twiddle scaling between them. There are no butterfly stages. One complete modular dot product of length k is finished per cycle, so each of the two passes takes n cycles. The prime p, the primitive nth root u and every derived constant are elaboration parameters. All coefficient tables are computed when the design is elaborated.

The host streams in n residues while the block is idle, then pulses `start`. The level on `inverse` is captured together with `start`. After a fixed latency the block streams out n residues on consecutive cycles and flags the last one with `done`. The forward result leaves the block in transposed index order. The inverse mode takes its input in that same transposed order, returns the vector in natural order, and applies the 1/n scaling. A forward result can therefore be fed straight back in to recover the original vector.

Top module: `sqf_ntt`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are low.
- R2: While `busy` is low, each cycle with `ld_valid` high stores `ld_data` mod p at the next load position. Positions run 0, 1, ..., n-1, and the position returns to 0 whenever a start is accepted.
- R3: In forward mode (`inverse` low at start), output word number i·k + j (0 ≤ i, j < k) equals the sum over m of a[m]·u^(m·(j·k+i)) mod p. This is transform coefficient j·k + i.
- R4: In inverse mode (`inverse` high at start), input word i·k + j is taken as coefficient X[j·k + i]. Output word m equals n⁻¹·Σc X[c]·u^(−m·c) mod p.
- R5: Running a forward transform and then feeding its output stream unchanged into an inverse transform returns the original vector, reduced mod p.
- R6: Every output word lies in [0, p-1].
- R7: If start is accepted on clock edge s, `out_valid` first rises after edge s + 2n. It then stays high for exactly n consecutive cycles, `done` is high on the last of them only, and `busy` is low on the cycle after `done`.
- R8: A load word presented in the same cycle that `start` is accepted is stored at the current position and is included in that run.
- R9: While `busy` is high, `ld_valid` and `start` have no effect. The running job's output is unchanged, and no new run follows it.
- R10: `inverse` is sampled only when start is accepted. Changes to it during a run do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe for one input residue |
| ld_data | input | DW = clog2(P) | Input word, reduced mod p when stored |
| start | input | 1 | Start request, accepted when idle |
| inverse | input | 1 | 1 = inverse transform, sampled with start |
| busy | output | 1 | High from accepted start through the last output |
| out_valid | output | 1 | Output word valid |
| out_data | output | DW | Output residue |
| done | output | 1 | Marks the last output word of a run |

## Verification
Loading and starting can land in the same cycle. The stored word must reach the matrix before the first pass reads it. The bench presents the final input word together with the start pulse and compares the run with the reference transform of the full vector. A second pair of functions, run control and host input, overlaps throughout a job: the bench keeps load strobes, start pulses and mode flips going during both passes and the drain, and then requires the exact reference output, the exact latency, and an idle block after `done`.

// File: rtl/sqf_pkg.sv
`timescale 1ns/1ps
package sqf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS1 = 2'd1,
    ST_PASS2 = 2'd2,
    ST_DRAIN = 2'd3
  } sqf_state_e;

  function automatic int unsigned mulmod(int unsigned a, int unsigned b, int unsigned m);
    return (a * b) % m;
  endfunction

  function automatic int unsigned addmod(int unsigned a, int unsigned b, int unsigned m);
    int unsigned s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction

  function automatic int unsigned powmod(int unsigned base, int unsigned e, int unsigned m);
    int unsigned r;
    int unsigned b;
    r = 1 % m;
    b = base % m;
    for (int i = 0; i < 32; i++) begin
      if (e[i]) r = mulmod(r, b, m);
      b = mulmod(b, b, m);
    end
    return r;
  endfunction

endpackage

// File: rtl/sqf_coef.sv
`timescale 1ns/1ps
module sqf_coef #(
  parameter int N    = 16,
  parameter int K    = 4,
  parameter int P    = 17,
  parameter int ROOT = 3,
  localparam int DW  = $clog2(P)
) (
  output logic [N-1:0][DW-1:0] u_fwd,
  output logic [N-1:0][DW-1:0] u_inv,
  output logic [K-1:0][DW-1:0] w_fwd,
  output logic [K-1:0][DW-1:0] w_inv,
  output logic [DW-1:0]        n_inv
);
  import sqf_pkg::*;

  localparam int unsigned UR   = powmod(32'(ROOT), 32'(N - 1), 32'(P));
  localparam int unsigned WR   = powmod(32'(ROOT), 32'(K), 32'(P));
  localparam int unsigned WRI  = powmod(UR, 32'(K), 32'(P));
  localparam int unsigned NINV = powmod(32'(N % P), 32'(P - 2), 32'(P));

  for (genvar e = 0; e < N; e++) begin : g_u
    assign u_fwd[e] = DW'(powmod(32'(ROOT), 32'(e), 32'(P)));
    assign u_inv[e] = DW'(powmod(UR, 32'(e), 32'(P)));
  end

  for (genvar e = 0; e < K; e++) begin : g_w
    assign w_fwd[e] = DW'(powmod(WR, 32'(e), 32'(P)));
    assign w_inv[e] = DW'(powmod(WRI, 32'(e), 32'(P)));
  end

  assign n_inv = DW'(NINV);
endmodule

// File: rtl/sqf_dot.sv
`timescale 1ns/1ps
module sqf_dot #(
  parameter int K   = 4,
  parameter int P   = 17,
  localparam int DW = $clog2(P)
) (
  input  logic [K-1:0][DW-1:0] xs,
  input  logic [K-1:0][DW-1:0] ys,
  input  logic [DW-1:0]        scale,
  output logic [DW-1:0]        res
);
  import sqf_pkg::*;

  logic [DW-1:0] prod [K];
  logic [DW-1:0] acc  [K];

  for (genvar t = 0; t < K; t++) begin : g_lane
    assign prod[t] = DW'(mulmod(32'(xs[t]), 32'(ys[t]), 32'(P)));
    if (t == 0) begin : g_first
      assign acc[t] = prod[t];
    end else begin : g_chain
      assign acc[t] = DW'(addmod(32'(acc[t-1]), 32'(prod[t]), 32'(P)));
    end
  end

  assign res = DW'(mulmod(32'(acc[K-1]), 32'(scale), 32'(P)));
endmodule

// File: rtl/sqf_seq.sv
`timescale 1ns/1ps
module sqf_seq #(
  parameter int N   = 16,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output sqf_pkg::sqf_state_e state,
  output logic [IW-1:0]       idx,
  output logic                start_take
);
  import sqf_pkg::*;

  logic idx_last;

  assign idx_last   = (idx == IW'(N - 1));
  assign start_take = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (start) state <= ST_PASS1;
        end
        ST_PASS1: begin
          idx <= idx_last ? '0 : idx + 1'b1;
          if (idx_last) state <= ST_PASS2;
        end
        ST_PASS2: begin
          idx <= idx_last ? '0 : idx + 1'b1;
          if (idx_last) state <= ST_DRAIN;
        end
        default: begin
          idx <= idx_last ? '0 : idx + 1'b1;
          if (idx_last) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sqf_ntt.sv
`timescale 1ns/1ps
module sqf_ntt #(
  parameter int N    = 16,
  parameter int K    = 4,
  parameter int P    = 17,
  parameter int ROOT = 3,
  localparam int DW  = $clog2(P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  input  logic          inverse,
  output logic          busy,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          done
);
  import sqf_pkg::*;

  localparam int IW = $clog2(N);
  localparam int KW = (K > 1) ? $clog2(K) : 1;

  sqf_state_e    state;
  logic [IW-1:0] idx;
  logic          start_take;
  logic          ld_take;
  logic          mode_q;
  logic [IW-1:0] ld_ptr;

  logic [DW-1:0] buf_a [N];
  logic [DW-1:0] buf_b [N];

  logic [N-1:0][DW-1:0] u_fwd, u_inv;
  logic [K-1:0][DW-1:0] w_fwd, w_inv;
  logic [DW-1:0]        n_inv;

  logic [K-1:0][DW-1:0] xs, ys;
  logic [DW-1:0]        scale;
  logic [DW-1:0]        dot_res;
  logic [KW-1:0]        row, col;
  logic                 pass1, pass2, col_gather;

  sqf_seq #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .state(state), .idx(idx), .start_take(start_take)
  );

  sqf_coef #(.N(N), .K(K), .P(P), .ROOT(ROOT)) u_coef (
    .u_fwd(u_fwd), .u_inv(u_inv), .w_fwd(w_fwd), .w_inv(w_inv), .n_inv(n_inv)
  );

  sqf_dot #(.K(K), .P(P)) u_dot (
    .xs(xs), .ys(ys), .scale(scale), .res(dot_res)
  );

  assign ld_take    = (state == ST_IDLE) && ld_valid;
  assign pass1      = (state == ST_PASS1);
  assign pass2      = (state == ST_PASS2);
  assign col_gather = (pass1 && !mode_q) || (pass2 && mode_q);
  assign row        = KW'(32'(idx) / K);
  assign col        = KW'(32'(idx) % K);

  always_comb begin
    int src;
    int ci;
    for (int t = 0; t < K; t++) begin
      if (col_gather) begin
        src = t * K + int'(col);
        ci  = (int'(row) * t) % K;
      end else begin
        src = int'(row) * K + t;
        ci  = (t * int'(col)) % K;
      end
      xs[t] = pass2 ? buf_b[IW'(src)] : buf_a[IW'(src)];
      ys[t] = mode_q ? w_inv[KW'(ci)] : w_fwd[KW'(ci)];
    end
    ci = (int'(row) * int'(col)) % N;
    if (pass1) scale = mode_q ? u_inv[IW'(ci)] : u_fwd[IW'(ci)];
    else       scale = mode_q ? n_inv : DW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ld_ptr <= '0;
    end else if (start_take) begin
      mode_q <= inverse;
      ld_ptr <= '0;
    end else if (ld_take) begin
      ld_ptr <= (ld_ptr == IW'(N - 1)) ? '0 : ld_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_take)    buf_a[ld_ptr] <= DW'(32'(ld_data) % P);
    else if (pass2) buf_a[idx]    <= dot_res;
    if (pass1)      buf_b[idx]    <= dot_res;
  end

  assign busy      = (state != ST_IDLE);
  assign out_valid = (state == ST_DRAIN);
  assign out_data  = buf_a[idx];
  assign done      = out_valid && (idx == IW'(N - 1));
endmodule

// File: rtl/sqf_ntt_chk.sv
`timescale 1ns/1ps
module sqf_ntt_chk #(
  parameter int N   = 16,
  parameter int P   = 17,
  localparam int DW = $clog2(P)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          done,
  input logic          busy,
  input logic          start_take,
  input logic          ld_take,
  input logic          mode_q
);
  int lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     lat_cnt <= 0;
    else if (start_take)            lat_cnt <= 0;
    else if (busy && !out_valid)    lat_cnt <= lat_cnt + 1;
  end

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_data) < P)); // R6
  AST_DONE_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid); // R7
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!out_valid && !busy)); // R7
  AST_STREAM_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !done) |=> out_valid); // R7
  AST_START_SPAWNS: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> (busy && !out_valid)); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 2 * N)); // R7
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_take); // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q)); // R10
endmodule

bind sqf_ntt sqf_ntt_chk #(.N(N), .P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_data(out_data),
  .done(done), .busy(busy), .start_take(start_take), .ld_take(ld_take),
  .mode_q(mode_q)
);

// File: tb/sqf_ntt_test.sv
`timescale 1ns/1ps
module sqf_ntt_test;
  localparam int N  = 16;
  localparam int K  = 4;
  localparam int P  = 17;
  localparam int U  = 3;
  localparam int DW = $clog2(P);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [DW-1:0] ld_data = '0;
  logic start = 1'b0;
  logic inverse = 1'b0;
  logic busy, out_valid, done;
  logic [DW-1:0] out_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  sqf_ntt #(.N(N), .K(K), .P(P), .ROOT(U)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .start(start), .inverse(inverse), .busy(busy), .out_valid(out_valid),
    .out_data(out_data), .done(done)
  );

  function automatic int pw(int b, int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * b) % P;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fwd_ref(input int a[N], output int y[N]);
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++) begin
        int c = j * K + i;
        int s = 0;
        for (int m = 0; m < N; m++) s = (s + (a[m] % P) * pw(U, (m * c) % N)) % P;
        y[i * K + j] = s;
      end
  endtask

  task automatic inv_ref(input int s_in[N], output int y[N]);
    int x[N];
    int ui = pw(U, N - 1);
    int ni = pw(N % P, P - 2);
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++) x[j * K + i] = s_in[i * K + j] % P;
    for (int m = 0; m < N; m++) begin
      int s = 0;
      for (int c = 0; c < N; c++) s = (s + x[c] * pw(ui, (m * c) % N)) % P;
      y[m] = (s * ni) % P;
    end
  endtask

  task automatic run_vec(input int vin[N], input bit inv, input bit merged,
                         input bit disturb, output int got[N]);
    int lat = 0;
    for (int m = 0; m < N; m++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_data  = DW'(vin[m]);
      if (merged && m == N - 1) begin start = 1'b1; inverse = inv; end
    end
    @(negedge clk);
    ld_valid = 1'b0;
    if (!merged) begin
      start = 1'b1; inverse = inv;
      @(negedge clk);
    end
    start = 1'b0;
    while (!out_valid && lat < 4 * N) begin
      lat++;
      if (disturb) begin
        ld_valid = 1'b1;
        ld_data  = DW'($urandom);
        start    = 1'($urandom);
        inverse  = ~inverse;
      end
      @(negedge clk);
    end
    chk(lat == 2 * N, "R7 latency", lat, 2 * N);
    for (int n = 0; n < N; n++) begin
      got[n] = int'(out_data);
      chk(out_valid == 1'b1, "R7 valid run", int'(out_valid), 1);
      chk(done == (n == N - 1), "R7 done flag", int'(done), int'(n == N - 1));
      chk(got[n] < P, "R6 range", got[n], P - 1);
      if (disturb && n < N - 1) begin
        ld_valid = 1'b1; start = 1'b1; ld_data = DW'($urandom);
      end else begin
        ld_valid = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    chk(busy == 1'b0, "R9 idle after done", int'(busy), 0);
    chk(out_valid == 1'b0, "R9 no extra run", int'(out_valid), 0);
    inverse = 1'b0;
  endtask

  task automatic cmp(input int got[N], input int exp[N], input string req);
    for (int m = 0; m < N; m++) chk(got[m] == exp[m], req, got[m], exp[m]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v[N], g[N], e[N], g2[N];
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);

    // R3 impulse: every coefficient is one
    for (int m = 0; m < N; m++) v[m] = (m == 0) ? 1 : 0;
    run_vec(v, 1'b0, 1'b0, 1'b0, g);
    fwd_ref(v, e);
    cmp(g, e, "R3 impulse");
    for (int m = 0; m < N; m++) chk(g[m] == 1, "R3 impulse ones", g[m], 1);

    // R3 all p-1
    for (int m = 0; m < N; m++) v[m] = P - 1;
    run_vec(v, 1'b0, 1'b0, 1'b0, g);
    fwd_ref(v, e);
    cmp(g, e, "R3 max");

    // R2 raw words above p are reduced on load
    for (int m = 0; m < N; m++) v[m] = P + (m % ((1 << DW) - P));
    run_vec(v, 1'b0, 1'b0, 1'b0, g);
    fwd_ref(v, e);
    cmp(g, e, "R2 reduce");

    // R3 random forward
    for (int r = 0; r < 3; r++) begin
      for (int m = 0; m < N; m++) v[m] = int'($urandom % P);
      run_vec(v, 1'b0, 1'b0, 1'b0, g);
      fwd_ref(v, e);
      cmp(g, e, "R3 random");
    end

    // R8 last word together with start
    for (int m = 0; m < N; m++) v[m] = int'($urandom % P);
    run_vec(v, 1'b0, 1'b1, 1'b0, g);
    fwd_ref(v, e);
    cmp(g, e, "R8 merged");

    // R9 R10 host activity while busy
    for (int m = 0; m < N; m++) v[m] = int'($urandom % P);
    run_vec(v, 1'b0, 1'b0, 1'b1, g);
    fwd_ref(v, e);
    cmp(g, e, "R9 R10 disturbed fwd");

    // R4 inverse random
    for (int r = 0; r < 2; r++) begin
      for (int m = 0; m < N; m++) v[m] = int'($urandom % P);
      run_vec(v, 1'b1, 1'b0, r == 1, g);
      inv_ref(v, e);
      cmp(g, e, "R4 inverse");
    end

    // R5 round trip
    for (int r = 0; r < 3; r++) begin
      for (int m = 0; m < N; m++) v[m] = int'($urandom % P);
      run_vec(v, 1'b0, 1'b0, 1'b0, g);
      run_vec(g, 1'b1, r == 2, 1'b0, g2);
      cmp(g2, v, "R5 round trip");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule